// File: doc/BRIEF.md
# Sound DSP DMA Transfer Controller

This block turns decoded sound-processor command bytes into a playback transfer. A command arrives together with up to three parameter bytes. From them the block chooses the sample width, mono or stereo, signed or unsigned data, and whether the block stops or repeats at its end. It then holds a count of remaining transfer units, which the downstream datapath decrements through a simple request and acknowledge handshake.

Output is gated by the mask state of the DMA channel. A started transfer waits until the channel is unmasked, and masking it sends the block back to waiting. At the end of each block the block pulses an 8-bit or a 16-bit interrupt request, chosen by the transfer width. It then either goes idle or reloads the count from the stored total. Commands for pause, resume and leaving auto-init mode act on a running transfer. When no 16-bit channel is configured, a 16-bit transfer is flagged to run aliased on the 8-bit channel.

Top module: `dsp_dma_ctrl`

## Requirements
- R1: After reset, remaining_o is 0, smp_req_o, waiting_o and paused_o are low, and wide_o, aliased_o, stereo_o, signed_o, autoinit_o, irq8_o and irq16_o are all low.
- R2: Commands 0x14, 0x24 and 0x91 start an 8-bit single-cycle transfer with length 1 + par0_i + 256*par1_i. They leave stereo_o and signed_o at their previous values.
- R3: Commands whose high nibble is 0xB or 0xC and whose low nibble is 0, 2, 4 or 6 start a generic transfer. Command bit 4 set means 16-bit (wide_o), and command bit 2 set means auto-init. par0_i bit 5 gives stereo_o and par0_i bit 4 gives signed_o. The length is 1 + par1_i + 256*par2_i, up to 65536.
- R4: A started transfer shows waiting_o. smp_req_o rises only in the cycle after dma_unmask_i is seen high. A low dma_unmask_i returns the block to waiting with the count held.
- R5: Each smp_ack_i seen while smp_req_o is high and cmd_valid_i is low lowers remaining_o by one. An acknowledge at any other time has no effect.
- R6: When a single-cycle transfer's count reaches zero, the block goes idle: remaining_o is 0 and smp_req_o is low.
- R7: When an auto-init transfer's count reaches zero, remaining_o reloads to the stored total and the transfer keeps running.
- R8: At each block end, a one-cycle pulse appears on irq16_o for a 16-bit transfer and on irq8_o for any other transfer. The pulse appears in the cycle after the last acknowledge.
- R9: Commands 0x1C and 0x90 start an 8-bit auto-init transfer that reuses the stored total. They are ignored while the stored total is zero, as it is after reset.
- R10: When a 16-bit transfer starts with hi_chan_i equal to 0xFF, aliased_o and wide_o are both high, and block end still raises irq16_o.
- R11: Commands 0xD0 and 0xD5 pause a waiting or running transfer: paused_o goes high, smp_req_o goes low, and unmasking does not resume it. In idle these commands are ignored. Command 0xD4 returns a paused transfer to waiting.
- R12: Command 0xDA clears autoinit_o, so the running transfer ends and goes idle after its current block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command byte and parameters valid this cycle |
| cmd_i | input | 8 | Command byte |
| par0_i | input | 8 | First parameter byte (mode byte for generic commands) |
| par1_i | input | 8 | Second parameter byte |
| par2_i | input | 8 | Third parameter byte |
| hi_chan_i | input | 8 | Configured 16-bit channel, 0xFF when absent |
| dma_unmask_i | input | 1 | DMA channel unmasked |
| smp_ack_i | input | 1 | Datapath consumed one transfer unit |
| smp_req_o | output | 1 | Transfer running, units may be consumed |
| waiting_o | output | 1 | Transfer started, waiting for unmask |
| paused_o | output | 1 | Transfer paused by command |
| wide_o | output | 1 | 16-bit sample format |
| aliased_o | output | 1 | 16-bit data carried on the 8-bit channel |
| stereo_o | output | 1 | Stereo data |
| signed_o | output | 1 | Signed data |
| autoinit_o | output | 1 | Count reloads at block end |
| remaining_o | output | LEN_W+1 | Units left in the current block |
| irq8_o | output | 1 | 8-bit block-end interrupt pulse |
| irq16_o | output | 1 | 16-bit block-end interrupt pulse |

## Verification
The bench targets the count boundary at full length (65536), where a design that dropped the extra count bit would start at zero. It checks the reload at the end of an auto-init block, where a faulty design would either stop or lose a unit. Legacy auto-init is tested straight after reset to confirm it is ignored while no total is stored. Acknowledges are sent while the transfer is waiting or paused; a design that counted them would drain the block early. The no-16-bit-channel fallback is run to its end, because a design that picked the interrupt by channel instead of by width would raise the 8-bit request there.

// File: rtl/dsp_dma_pkg.sv
package dsp_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN, ST_HOLD} xfer_state_e;

  localparam logic [7:0] NO_HI_CHAN = 8'hFF;

  typedef struct packed {
    logic start;
    logic generic;
    logic wide;
    logic autoinit;
    logic reuse_len;
    logic pause;
    logic resume;
    logic exit_auto;
  } cmd_dec_t;
endpackage

// File: rtl/dsp_dma_decode.sv
module dsp_dma_decode
  import dsp_dma_pkg::*;
(
  input  logic [7:0] cmd_i,
  output cmd_dec_t   dec_o
);
  logic gen_hit;

  // even B0..B6 / C0..C6
  assign gen_hit = (cmd_i[7:4] == 4'hB || cmd_i[7:4] == 4'hC) &&
                   !cmd_i[3] && !cmd_i[0];

  always_comb begin
    dec_o = '0;
    if (gen_hit) begin
      dec_o.start    = 1'b1;
      dec_o.generic  = 1'b1;
      dec_o.wide     = cmd_i[4];
      dec_o.autoinit = cmd_i[2];
    end
    case (cmd_i)
      8'h14, 8'h24, 8'h91: dec_o.start = 1'b1;
      8'h1C, 8'h90: begin
        dec_o.start     = 1'b1;
        dec_o.autoinit  = 1'b1;
        dec_o.reuse_len = 1'b1;
      end
      8'hD0, 8'hD5: dec_o.pause     = 1'b1;
      8'hD4:        dec_o.resume    = 1'b1;
      8'hDA:        dec_o.exit_auto = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/dsp_dma_counter.sv
module dsp_dma_counter #(
  parameter  int LEN_W = 16,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             reuse_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic             step_i,
  input  logic             autoinit_i,
  output logic [CNT_W-1:0] left_o,
  output logic             last_o,
  output logic             total_zero_o
);
  logic [CNT_W-1:0] total_q, left_q, load_val;

  assign load_val     = reuse_i ? total_q : CNT_W'(len_m1_i) + CNT_W'(1);
  assign last_o       = (left_q == CNT_W'(1));
  assign total_zero_o = (total_q == '0);
  assign left_o       = left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q <= '0;
      left_q  <= '0;
    end else if (load_i) begin
      total_q <= load_val;
      left_q  <= load_val;
    end else if (step_i) begin
      if (last_o) left_q <= autoinit_i ? total_q : '0;
      else        left_q <= left_q - CNT_W'(1);
    end
  end

  assert_left_bounded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= total_q);
endmodule

// File: rtl/dsp_dma_seq.sv
module dsp_dma_seq
  import dsp_dma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  cmd_dec_t    dec_i,
  input  logic [7:0]  mode_i,
  input  logic [7:0]  hi_chan_i,
  input  logic        unmask_i,
  input  logic        ack_i,
  input  logic        last_i,
  input  logic        total_zero_i,
  output xfer_state_e state_o,
  output logic        load_o,
  output logic        step_o,
  output logic        wide_o,
  output logic        aliased_o,
  output logic        stereo_o,
  output logic        signed_o,
  output logic        autoinit_o,
  output logic        irq8_o,
  output logic        irq16_o
);
  xfer_state_e state_q;
  logic wide_q, alias_q, stereo_q, sign_q, auto_q, irq8_q, irq16_q;
  logic active;

  assign active  = (state_q == ST_WAIT) || (state_q == ST_RUN);
  assign load_o  = cmd_valid_i && dec_i.start && !(dec_i.reuse_len && total_zero_i);
  assign step_o  = !cmd_valid_i && (state_q == ST_RUN) && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wide_q   <= 1'b0;
      alias_q  <= 1'b0;
      stereo_q <= 1'b0;
      sign_q   <= 1'b0;
      auto_q   <= 1'b0;
      irq8_q   <= 1'b0;
      irq16_q  <= 1'b0;
    end else begin
      irq8_q  <= 1'b0;
      irq16_q <= 1'b0;
      if (load_o) begin
        state_q <= ST_WAIT;
        auto_q  <= dec_i.autoinit;
        wide_q  <= dec_i.wide;
        alias_q <= dec_i.wide && (hi_chan_i == NO_HI_CHAN);
        if (dec_i.generic) begin
          stereo_q <= mode_i[5];
          sign_q   <= mode_i[4];
        end
      end else if (cmd_valid_i) begin
        if (dec_i.pause && active)                state_q <= ST_HOLD;
        if (dec_i.resume && state_q == ST_HOLD)   state_q <= ST_WAIT;
        if (dec_i.exit_auto)                      auto_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_WAIT: if (unmask_i) state_q <= ST_RUN;
          ST_RUN: begin
            if (step_o && last_i) begin
              irq16_q <= wide_q;
              irq8_q  <= !wide_q;
            end
            if (step_o && last_i && !auto_q) state_q <= ST_IDLE;
            else if (!unmask_i)              state_q <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o    = state_q;
  assign wide_o     = wide_q;
  assign aliased_o  = alias_q;
  assign stereo_o   = stereo_q;
  assign signed_o   = sign_q;
  assign autoinit_o = auto_q;
  assign irq8_o     = irq8_q;
  assign irq16_o    = irq16_q;

  assert_irq16_wide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq16_q |-> wide_q);
  assert_irq8_narrow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq8_q |-> !wide_q);
  assert_alias_wide_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_q |-> wide_q);
  assert_hold_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !cmd_valid_i) |=> state_q == ST_HOLD);
endmodule

// File: rtl/dsp_dma_ctrl.sv
module dsp_dma_ctrl
  import dsp_dma_pkg::*;
#(
  parameter  int LEN_W = 16,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_i,
  input  logic [7:0]       par0_i,
  input  logic [7:0]       par1_i,
  input  logic [7:0]       par2_i,
  input  logic [7:0]       hi_chan_i,
  input  logic             dma_unmask_i,
  input  logic             smp_ack_i,
  output logic             smp_req_o,
  output logic             waiting_o,
  output logic             paused_o,
  output logic             wide_o,
  output logic             aliased_o,
  output logic             stereo_o,
  output logic             signed_o,
  output logic             autoinit_o,
  output logic [CNT_W-1:0] remaining_o,
  output logic             irq8_o,
  output logic             irq16_o
);
  cmd_dec_t         dec;
  xfer_state_e      state;
  logic             load, step, last, total_zero;
  logic [LEN_W-1:0] len_m1;

  dsp_dma_decode u_decode (.cmd_i(cmd_i), .dec_o(dec));

  // generic commands carry the mode byte first
  assign len_m1 = dec.generic ? LEN_W'({par2_i, par1_i}) : LEN_W'({par1_i, par0_i});

  dsp_dma_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .dec_i(dec),
    .mode_i(par0_i), .hi_chan_i(hi_chan_i), .unmask_i(dma_unmask_i),
    .ack_i(smp_ack_i), .last_i(last), .total_zero_i(total_zero),
    .state_o(state), .load_o(load), .step_o(step), .wide_o(wide_o),
    .aliased_o(aliased_o), .stereo_o(stereo_o), .signed_o(signed_o),
    .autoinit_o(autoinit_o), .irq8_o(irq8_o), .irq16_o(irq16_o)
  );

  dsp_dma_counter #(.LEN_W(LEN_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .reuse_i(dec.reuse_len),
    .len_m1_i(len_m1), .step_i(step), .autoinit_i(autoinit_o),
    .left_o(remaining_o), .last_o(last), .total_zero_o(total_zero)
  );

  assign smp_req_o = (state == ST_RUN);
  assign waiting_o = (state == ST_WAIT);
  assign paused_o  = (state == ST_HOLD);

  assert_idle_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> remaining_o == '0);
  assert_req_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_req_o |-> remaining_o != '0);
endmodule

// File: tb/dsp_dma_ctrl_tb.sv
`timescale 1ns/1ps
module dsp_dma_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0;
  logic [7:0]  cmd = 0, p0 = 0, p1 = 0, p2 = 0, hc = 8'h05;
  logic        unmask = 0, ack = 0;
  logic        req, waiting, paused, wide, aliased, stereo, sgn, auto_o, irq8, irq16;
  logic [16:0] left;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dsp_dma_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .par0_i(p0), .par1_i(p1), .par2_i(p2), .hi_chan_i(hc),
    .dma_unmask_i(unmask), .smp_ack_i(ack), .smp_req_o(req),
    .waiting_o(waiting), .paused_o(paused), .wide_o(wide), .aliased_o(aliased),
    .stereo_o(stereo), .signed_o(sgn), .autoinit_o(auto_o),
    .remaining_o(left), .irq8_o(irq8), .irq16_o(irq16)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send(input logic [7:0] c, a, b, d);
    cmd = c; p0 = a; p1 = b; p2 = d; cmd_valid = 1;
    cyc();
    cmd_valid = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  function automatic logic [16:0] gen_len(input logic [7:0] lo, hi);
    return 17'(lo) + (17'(hi) << 8) + 17'd1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); cyc();
    // R1
    chk("R1 remaining", left, 0);
    chk("R1 status", {req, waiting, paused}, 0);
    chk("R1 flags", {wide, aliased, stereo, sgn, auto_o, irq8, irq16}, 0);
    rst_n = 1; cyc();

    // R9 legacy auto with no stored total
    send(8'h1C, 0, 0, 0);
    chk("R9 ignored empty total", {waiting, left}, 0);
    // R11 pause in idle
    send(8'hD0, 0, 0, 0);
    chk("R11 pause idle ignored", paused, 0);

    // R2/R4/R5/R6/R8 legacy single, length 3
    send(8'h14, 8'd2, 8'd0, 0);
    chk("R2 waiting", waiting, 1);
    chk("R2 length", left, 3);
    chk("R2 flags", {wide, auto_o}, 0);
    cyc(); cyc();
    chk("R4 masked no req", req, 0);
    pulse_ack();
    chk("R5 ack while waiting ignored", left, 3);
    unmask = 1; cyc();
    chk("R4 unmask starts", req, 1);
    pulse_ack();
    chk("R5 decrement", left, 2);
    unmask = 0; cyc();
    chk("R4 mask back to waiting", {waiting, req}, 2'b10);
    chk("R4 count held", left, 2);
    unmask = 1; cyc();
    pulse_ack();
    pulse_ack();
    chk("R6 idle after single", {req, waiting, left}, 0);
    chk("R8 irq8 pulse", {irq8, irq16}, 2'b10);
    cyc();
    chk("R8 pulse one cycle", irq8, 0);

    // R9/R7/R11/R12 legacy auto-init reuses total 3
    send(8'h90, 8'hAA, 8'hAA, 0);
    chk("R9 reuse total", left, 3);
    chk("R9 autoinit", auto_o, 1);
    cyc();
    for (int k = 0; k < 3; k++) pulse_ack();
    chk("R7 reload", left, 3);
    chk("R7 still running", req, 1);
    chk("R8 auto irq8", irq8, 1);
    send(8'hD5, 0, 0, 0);
    chk("R11 paused", {paused, req}, 2'b10);
    cyc();
    chk("R11 unmask no resume", paused, 1);
    pulse_ack();
    chk("R11 ack while paused ignored", left, 3);
    send(8'hD4, 0, 0, 0);
    chk("R11 resume to waiting", {waiting, paused}, 2'b10);
    cyc();
    chk("R11 running again", req, 1);
    send(8'hDA, 0, 0, 0);
    chk("R12 autoinit cleared", auto_o, 0);
    for (int k = 0; k < 3; k++) pulse_ack();
    chk("R12 ends after block", {req, left}, 0);

    // R3 generic flags and full length
    send(8'hB6, 8'h30, 8'd1, 8'd0);
    chk("R3 B6 flags", {wide, aliased, stereo, sgn, auto_o}, 5'b10111);
    chk("R3 B6 length", left, 2);
    send(8'hC0, 8'h20, 8'hFF, 8'hFF);
    chk("R3 C0 flags", {wide, stereo, sgn, auto_o}, 4'b0100);
    chk("R3 max length", left, 17'h10000);
    send(8'h24, 8'd0, 8'd0, 0);
    chk("R2 keeps stereo", {stereo, sgn}, 2'b10);
    chk("R2 length one", left, 1);
    cyc();
    pulse_ack();
    chk("R6 single unit done", {req, irq8}, 2'b01);

    // R10 aliased
    hc = 8'hFF;
    send(8'hB0, 8'h00, 8'd1, 8'd0);
    chk("R10 aliased flags", {wide, aliased}, 2'b11);
    cyc();
    pulse_ack(); pulse_ack();
    chk("R10 irq16", {irq16, irq8}, 2'b10);

    // random generic transfers
    for (int it = 0; it < 30; it++) begin
      logic [7:0] c, m, lo;
      logic [16:0] len;
      logic w, au;
      c  = (($urandom % 2) ? 8'hB0 : 8'hC0) | 8'(($urandom % 4) << 1);
      m  = 8'($urandom);
      lo = 8'($urandom % 5);
      hc = ($urandom % 2) ? 8'hFF : 8'h06;
      len = gen_len(lo, 8'd0);
      w = c[4]; au = c[2];
      send(c, m, lo, 8'd0);
      chk("R3 rnd length", left, len);
      chk("R3 rnd flags", {wide, aliased, stereo, sgn, auto_o},
          {w, w && (hc == 8'hFF), m[5], m[4], au});
      cyc();
      for (int k = 0; k < int'(len); k++) begin
        pulse_ack();
        if (k < int'(len) - 1) chk("R5 rnd count", left, len - 17'(k) - 1);
      end
      chk("R8 rnd irq", {irq16, irq8}, {w, !w});
      chk("R7 rnd end count", left, au ? len : 17'd0);
      if (au) begin
        send(8'hDA, 0, 0, 0);
        for (int k = 0; k < int'(len); k++) pulse_ack();
        chk("R12 rnd stop", {req, left}, 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule